// File: doc/BRIEF.md
# Indexed Voice Register Window

This block gives a host a narrow register port onto a bank of 16-bit registers that belong to individual synthesis voices. The host does not address the bank directly. It first loads an 8-bit voice selector and an 8-bit function selector, and then moves data through a 16-bit data port. Each access on the data port is either a full word or a single byte lane. The block forms the bank address from the two selectors. On a write it merges the byte lanes into the stored word, and on a read it returns the requested lane or the whole word.

Besides the per-voice bank, the window holds two global registers. The first is an active-voice count. The second is a control register whose bit 0 acts as a run flag: while that flag is low, stores into the voice bank are blocked. Writing the control register with the run flag low also puts the voice count back to its default.

Function codes for reads are the write codes with bit 7 set. Host accesses are single-cycle strobes. Read data is combinational.

Top module: `vrw_window`

## Requirements
- R1: The bank word index is formed from the low 5 bits of the voice selector as the high part and the low 4 bits of the function selector as the low part. This equals a byte address of voice*32 + function*2. Voice selector bits 7:5 have no effect.
- R2: Data-port writes with function codes 0x00 to 0x0D store into the selected voice word. Data-port reads with codes 0x80 to 0x8D return that same word.
- R3: A byte write (host_word=0) at offset 4 changes only bits 7:0 of the word, taking host_wdata[7:0]. A byte write at offset 5 places host_wdata[7:0] into bits 15:8 and keeps bits 7:0. A word write at either data offset replaces all 16 bits.
- R4: A byte read at offset 4 returns bits 7:0 of the selected value, zero-extended. A byte read at offset 5 returns bits 15:8 in the low byte, with the upper byte zero. A word read returns all 16 bits.
- R5: While control bit 0 is 0, writes to the voice bank with codes 0x00 to 0x0D leave the bank unchanged.
- R6: Function code 0x0E writes host_wdata[7:0] into the voice count. Code 0x8E reads it back. After reset the voice count is 0xCD.
- R7: A data-port read with any function code other than 0x80–0x8D, 0x8E or 0xCC returns 0xFFFF at either width. A read at an offset other than 2, 3, 4 or 5 also returns 0xFFFF.
- R8: Function code 0x4C writes host_wdata[7:0] into the control register, and code 0xCC reads it back. When written bit 0 is 0, the voice count is loaded with 0xCD and control bits 2:1 are stored as 0. The control register is 0 after reset.
- R9: The voice selector is written and read at offset 2, and the function selector at offset 3. Both read back zero-extended and both reset to 0.
- R10: host_rdata is 0 whenever host_rd is low. A write strobe takes effect at the rising clock edge on which it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 4 | Port offset: 2 voice select, 3 function select, 4 data low/word, 5 data high |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Read strobe qualifying host_rdata |
| host_word | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Combinational read data |

## Verification
The assertions assume that the host never raises host_rd and host_wr in the same cycle. They also assume that the host drives known values on the address, width and data inputs whenever a strobe is high. The bench's driver tasks enforce both assumptions. Each task drives exactly one strobe for one cycle on the falling edge and drops it on the next falling edge, and it holds all other inputs at defined values between operations.

// File: rtl/vrw_pkg.sv
package vrw_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    localparam logic [3:0] OFS_VOICE   = 4'h2;
    localparam logic [3:0] OFS_FUNC    = 4'h3;
    localparam logic [3:0] OFS_DATA_LO = 4'h4;
    localparam logic [3:0] OFS_DATA_HI = 4'h5;

    localparam logic [7:0] FN_VOICE_LAST = 8'h0D;
    localparam logic [7:0] FN_RD_FLAG    = 8'h80;
    localparam logic [7:0] FN_COUNT      = 8'h0E;
    localparam logic [7:0] FN_CTRL       = 8'h4C;

    localparam logic [7:0] COUNT_DEFAULT = 8'hCD;
    localparam logic [7:0] CTRL_CLR_MASK = 8'hF9;

    typedef struct packed {
        logic [BYTE_W-1:0] voice_sel;
        logic [BYTE_W-1:0] func_sel;
        logic [BYTE_W-1:0] voice_cnt;
        logic [BYTE_W-1:0] ctrl;
    } win_regs_t;

endpackage

// File: rtl/vrw_addr_gen.sv
module vrw_addr_gen #(
    parameter int VOICE_W = 5,
    parameter int SLOT_W  = 4,
    parameter int SEL_W   = 8,
    localparam int IDX_W  = VOICE_W + SLOT_W
) (
    input  logic [SEL_W-1:0] voice_sel,
    input  logic [SEL_W-1:0] func_sel,
    output logic [IDX_W:0]   byte_addr,
    output logic [IDX_W-1:0] word_idx
);
    // byte address = voice * 2^(SLOT_W+1) + slot * 2
    assign byte_addr = {voice_sel[VOICE_W-1:0], func_sel[SLOT_W-1:0], 1'b0};
    assign word_idx  = byte_addr[IDX_W:1];
endmodule

// File: rtl/vrw_lane_merge.sv
module vrw_lane_merge #(
    parameter int BYTE_W  = 8,
    localparam int LANES  = 2,
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] wdata,
    input  logic              is_word,
    input  logic              hi_port,
    output logic [WORD_W-1:0] new_word
);
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        localparam logic LANE_HI = (ln == 1);
        logic              hit;
        logic [BYTE_W-1:0] src;
        assign hit = is_word | (hi_port == LANE_HI);
        assign src = is_word ? wdata[ln*BYTE_W +: BYTE_W] : wdata[BYTE_W-1:0];
        assign new_word[ln*BYTE_W +: BYTE_W] = hit ? src : old_word[ln*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/vrw_voice_bank.sv
module vrw_voice_bank #(
    parameter int IDX_W  = 9,
    parameter int WORD_W = 16,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem_d [DEPTH];
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/vrw_window.sv
module vrw_window
    import vrw_pkg::*;
#(
    parameter int VOICE_W = 5,
    parameter int SLOT_W  = 4,
    localparam int IDX_W  = VOICE_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_word,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata
);
    win_regs_t state_d, state_q;

    logic [BYTE_W-1:0] cur_voice, cur_func, cur_cnt, cur_ctrl;
    assign cur_voice = state_q.voice_sel;
    assign cur_func  = state_q.func_sel;
    assign cur_cnt   = state_q.voice_cnt;
    assign cur_ctrl  = state_q.ctrl;

    logic [IDX_W:0]    byte_addr;
    logic [IDX_W-1:0]  word_idx;
    logic [WORD_W-1:0] bank_rdata, merged, rd_full;
    logic              data_port, hi_port, wr_voice_fn, rd_voice_fn, bank_we;
    logic              rd_known;

    vrw_addr_gen #(.VOICE_W(VOICE_W), .SLOT_W(SLOT_W), .SEL_W(BYTE_W)) u_addr (
        .voice_sel(cur_voice),
        .func_sel (cur_func),
        .byte_addr(byte_addr),
        .word_idx (word_idx)
    );

    assign data_port   = (host_addr == OFS_DATA_LO) || (host_addr == OFS_DATA_HI);
    assign hi_port     = (host_addr == OFS_DATA_HI);
    assign wr_voice_fn = (cur_func <= FN_VOICE_LAST);
    assign rd_voice_fn = (cur_func >= FN_RD_FLAG) && (cur_func <= (FN_RD_FLAG | FN_VOICE_LAST));
    assign bank_we     = host_wr && data_port && wr_voice_fn && cur_ctrl[0];

    vrw_lane_merge #(.BYTE_W(BYTE_W)) u_merge (
        .old_word(bank_rdata),
        .wdata   (host_wdata),
        .is_word (host_word),
        .hi_port (hi_port),
        .new_word(merged)
    );

    vrw_voice_bank #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (bank_we),
        .idx  (word_idx),
        .wdata(merged),
        .rdata(bank_rdata)
    );

    // next-state of the global registers
    always_comb begin
        state_d = state_q;
        if (host_wr) begin
            unique case (host_addr)
                OFS_VOICE: state_d.voice_sel = host_wdata[BYTE_W-1:0];
                OFS_FUNC:  state_d.func_sel  = host_wdata[BYTE_W-1:0];
                OFS_DATA_LO, OFS_DATA_HI: begin
                    if (cur_func == FN_COUNT) begin
                        state_d.voice_cnt = host_wdata[BYTE_W-1:0];
                    end else if (cur_func == FN_CTRL) begin
                        if (host_wdata[0]) begin
                            state_d.ctrl = host_wdata[BYTE_W-1:0];
                        end else begin
                            state_d.ctrl      = host_wdata[BYTE_W-1:0] & CTRL_CLR_MASK;
                            state_d.voice_cnt = COUNT_DEFAULT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{voice_sel: '0, func_sel: '0, voice_cnt: COUNT_DEFAULT, ctrl: '0};
        end else begin
            state_q <= state_d;
        end
    end

    // read path
    always_comb begin
        rd_full  = '1;
        rd_known = 1'b1;
        if (rd_voice_fn) begin
            rd_full = bank_rdata;
        end else if (cur_func == (FN_RD_FLAG | FN_COUNT)) begin
            rd_full = {{BYTE_W{1'b0}}, cur_cnt};
        end else if (cur_func == (FN_RD_FLAG | FN_CTRL)) begin
            rd_full = {{BYTE_W{1'b0}}, cur_ctrl};
        end else begin
            rd_known = 1'b0;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            unique case (host_addr)
                OFS_VOICE: host_rdata = {{BYTE_W{1'b0}}, cur_voice};
                OFS_FUNC:  host_rdata = {{BYTE_W{1'b0}}, cur_func};
                OFS_DATA_LO, OFS_DATA_HI: begin
                    if (!rd_known || host_word) begin
                        host_rdata = rd_full;
                    end else if (hi_port) begin
                        host_rdata = {{BYTE_W{1'b0}}, rd_full[WORD_W-1:BYTE_W]};
                    end else begin
                        host_rdata = {{BYTE_W{1'b0}}, rd_full[BYTE_W-1:0]};
                    end
                end
                default: host_rdata = '1;
            endcase
        end
    end
endmodule

// File: rtl/vrw_window_chk.sv
module vrw_window_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  host_addr,
    input logic        host_wr,
    input logic        host_rd,
    input logic        host_word,
    input logic [15:0] host_wdata,
    input logic [15:0] host_rdata,
    input logic [7:0]  cur_voice,
    input logic [7:0]  cur_func,
    input logic [7:0]  cur_cnt,
    input logic [7:0]  cur_ctrl
);
    logic on_data, fn_known;
    assign on_data  = (host_addr == 4'h4) || (host_addr == 4'h5);
    assign fn_known = ((cur_func >= 8'h80) && (cur_func <= 8'h8D)) ||
                      (cur_func == 8'h8E) || (cur_func == 8'hCC);

    // R8
    ctrl_clear_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && on_data && cur_func == 8'h4C && !host_wdata[0])
        |=> (cur_cnt == 8'hCD && cur_ctrl[2:1] == 2'b00 && !cur_ctrl[0]));

    // R7
    unknown_fn_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && on_data && !fn_known) |-> host_rdata == 16'hFFFF);

    // R9
    voice_sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 4'h2) |=> cur_voice == $past(host_wdata[7:0]));

    // R4
    hi_byte_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_word && host_addr == 4'h5 && fn_known) |-> host_rdata[15:8] == 8'h00);

    // R10
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> host_rdata == 16'h0000);
endmodule

bind vrw_window vrw_window_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_word (host_word),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .cur_voice (cur_voice),
    .cur_func  (cur_func),
    .cur_cnt   (cur_cnt),
    .cur_ctrl  (cur_ctrl)
);

// File: tb/vrw_window_test.sv
module vrw_window_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_word = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    vrw_window uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_word(host_word), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    task automatic idle();
        host_wr = 1'b0; host_rd = 1'b0; host_addr = 4'h0; host_wdata = '0; host_word = 1'b0;
    endtask

    task automatic do_wr(input logic [3:0] a, input logic w, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_word = w; host_wdata = d; host_wr = 1'b1; host_rd = 1'b0;
        @(negedge clk);
        idle();
    endtask

    task automatic do_rd(input logic [3:0] a, input logic w, input logic [15:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        host_addr = a; host_word = w; host_rd = 1'b1; host_wr = 1'b0;
        @(negedge clk);
        idle();
    endtask

    task automatic pick(input logic [7:0] v, input logic [7:0] f);
        do_wr(4'h2, 1'b0, {8'h00, v});
        do_wr(4'h3, 1'b0, {8'h00, f});
    endtask

    // monitor: sample read data mid-cycle, away from the active edge
    always @(negedge clk) begin
        #3;
        if (host_rd && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (host_rdata !== e) begin
                errors++;
                $display("FAIL %s: got %h expected %h", t, host_rdata, e);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        do_rd(4'h2, 1'b0, 16'h0000, "R9 voice sel reset");
        do_rd(4'h3, 1'b0, 16'h0000, "R9 func sel reset");
        pick(8'h00, 8'h8E);
        do_rd(4'h4, 1'b1, 16'h00CD, "R6 count reset");
        pick(8'h00, 8'hCC);
        do_rd(4'h4, 1'b1, 16'h0000, "R8 ctrl reset");
        do_rd(4'h3, 1'b0, 16'h00CC, "R9 func sel readback");

        // gated write while run flag low
        pick(8'h03, 8'h02);
        do_wr(4'h4, 1'b1, 16'h1234);
        pick(8'h03, 8'h82);
        do_rd(4'h4, 1'b1, 16'h0000, "R5 write blocked");

        // open the bank
        pick(8'h00, 8'h4C);
        do_wr(4'h4, 1'b1, 16'h0007);
        pick(8'h00, 8'hCC);
        do_rd(4'h4, 1'b1, 16'h0007, "R8 ctrl readback");

        pick(8'h03, 8'h02);
        do_wr(4'h4, 1'b1, 16'h1234);
        pick(8'h03, 8'h82);
        do_rd(4'h4, 1'b1, 16'h1234, "R2 word write/read");
        do_rd(4'h4, 1'b0, 16'h0034, "R4 low byte read");
        do_rd(4'h5, 1'b0, 16'h0012, "R4 high byte read");

        pick(8'h03, 8'h02);
        do_wr(4'h4, 1'b0, 16'hFFAB);
        pick(8'h03, 8'h82);
        do_rd(4'h4, 1'b1, 16'h12AB, "R3 low byte write");
        pick(8'h03, 8'h02);
        do_wr(4'h5, 1'b0, 16'h77CD);
        pick(8'h03, 8'h82);
        do_rd(4'h5, 1'b1, 16'hCDAB, "R3 high byte write");

        // voice selector upper bits ignored
        pick(8'h23, 8'h82);
        do_rd(4'h4, 1'b1, 16'hCDAB, "R1 voice mask");
        do_rd(4'h2, 1'b0, 16'h0023, "R9 voice sel readback");

        pick(8'h1F, 8'h0D);
        do_wr(4'h5, 1'b1, 16'hBEEF);
        pick(8'h1F, 8'h8D);
        do_rd(4'h4, 1'b1, 16'hBEEF, "R2 last voice last code");
        pick(8'h1E, 8'h8D);
        do_rd(4'h4, 1'b1, 16'h0000, "R1 neighbour voice untouched");
        pick(8'h03, 8'h83);
        do_rd(4'h4, 1'b1, 16'h0000, "R1 neighbour slot untouched");

        // voice count
        pick(8'h00, 8'h0E);
        do_wr(4'h4, 1'b1, 16'h551C);
        pick(8'h00, 8'h8E);
        do_rd(4'h4, 1'b1, 16'h001C, "R6 count write");
        do_rd(4'h5, 1'b0, 16'h0000, "R4 count high byte");

        // unknown functions and offsets
        pick(8'h03, 8'h8F);
        do_rd(4'h4, 1'b1, 16'hFFFF, "R7 code 0x8F");
        pick(8'h03, 8'h0E);
        do_rd(4'h5, 1'b0, 16'hFFFF, "R7 write code on read");
        do_rd(4'hA, 1'b1, 16'hFFFF, "R7 unmapped offset");

        // control write with run flag clear
        pick(8'h00, 8'h4C);
        do_wr(4'h4, 1'b1, 16'h00F6);
        pick(8'h00, 8'h8E);
        do_rd(4'h4, 1'b1, 16'h00CD, "R8 count reloaded");
        pick(8'h00, 8'hCC);
        do_rd(4'h4, 1'b1, 16'h00F0, "R8 ctrl bits 2:1 cleared");
        pick(8'h03, 8'h02);
        do_wr(4'h4, 1'b1, 16'h0000);
        pick(8'h03, 8'h82);
        do_rd(4'h4, 1'b1, 16'hCDAB, "R5 blocked after clear");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule